// File: doc/BRIEF.md
# Three-Wire Serial Register Interface

This block is a write-only serial slave for a synthesizer control path. A host pulls the active-low select line low, toggles a serial clock and presents one bit per rising clock edge, most significant bit first. When the select line returns high, the block looks at how many bits arrived. A frame of sixteen or more bits is an addressed register write: a 4-bit address followed by 12 bits of data. A frame of 2 to 12 bits carries no address and becomes a modulation sample. Any other length is dropped.

All serial pins are brought into the local clock domain through synchronizers and sampled there. The block holds ten 12-bit registers and exposes them as one flat vector. Each accepted transfer raises a one-cycle strobe: one for addressed writes and one for modulation samples, the second with the sample length.

Two flags in the modulation control register change how frames are decoded. One makes every frame a sample, whatever its length. The other takes samples from an alternate input pin instead of the main data pin. For board loopback tests, a 3-bit select field makes the received stream reappear on the multiplexer output, updated on falling serial clock edges.

Top module: `serial_reg_slave`

## Requirements
- R1: A frame of exactly 16 bits is sent MSB first and read as address (first 4 bits) then data (last 12 bits). If the address is 0 to 9, that register is loaded when the select line rises, and `wr_stb` pulses with `wr_addr`/`wr_data`.
- R2: If more than 16 bits are clocked in during one select window, only the last 16 bits decide the address and data.
- R3: A frame of 2 to 12 bits is a modulation sample. Its bits are stored right-aligned, with zero above them, in register 9. `mod_stb` pulses with `mod_data` and `mod_len` equal to the bit count.
- R4: Frames of 0, 1, 13, 14 or 15 bits, and 16-bit frames whose address is 10 to 15, change no register and raise no strobe.
- R5: After reset, registers 0 and 3 hold 0x006, all other registers hold 0x000, and `mux_out` is 0.
- R6: While bit 1 of register 8 is set, every frame of 2 or more bits is a modulation sample and no addressed write occurs. A frame longer than 12 bits keeps its last 12 bits and reports length 12.
- R7: While bit 0 of register 8 is set, sample bits are taken from `mod_in` rather than `sdata`. Addressed writes still come from `sdata`.
- R8: When bits 8:6 of register 7 equal 3'b101, `mux_out` shows the most recently received `sdata` bit, updated after each falling serial clock edge. For any other code, `mux_out` is 0.
- R9: Each strobe is high for exactly one clock cycle per accepted transfer, and the two strobes are never high together.
- R10: Serial clock edges while the select line is high shift nothing and do not affect the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; its rising edge ends a frame |
| sdata | input | 1 | Main serial data pin |
| mod_in | input | 1 | Alternate data pin for modulation samples |
| mux_out | output | 1 | Loopback output of the received stream |
| reg_bank | output | 120 | Ten 12-bit registers, register i at bits i*12+11 : i*12 |
| wr_stb | output | 1 | One-cycle pulse for an addressed write |
| wr_addr | output | 4 | Address of the last addressed write |
| wr_data | output | 12 | Data of the last addressed write |
| mod_stb | output | 1 | One-cycle pulse for a modulation sample |
| mod_data | output | 12 | Last sample, right-aligned and zero-extended |
| mod_len | output | 4 | Bit count of the last sample |

## Verification
With the alternate-pin flag set, one select window carries different bit streams on `sdata` and `mod_in`. The frame length alone decides which stream is stored. The bench sends the same two-stream transfer at 5 bits, where the `mod_in` bits must land in register 9, and at 16 bits, where the `sdata` bits must write the addressed register. Loopback runs while bits are still being shifted in: after every falling serial edge, `mux_out` is compared with the bit just sent.

// File: rtl/serial_reg_slave.sv
module serial_reg_slave #(
  parameter int DW          = 12,
  parameter int AW          = 4,
  parameter int NREG        = 10,
  parameter int SYNC        = 2,
  parameter int MIN_LEN     = 2,
  parameter int MUX_REG     = 7,
  parameter int MODCTL_REG  = 8,
  parameter int MODDAT_REG  = 9,
  parameter int MUX_LSB     = 6,
  parameter logic [2:0] LOOP_CODE = 3'b101,
  parameter int ALT_BIT     = 0,
  parameter int NOADDR_BIT  = 1,
  parameter int PRESET_A    = 0,
  parameter int PRESET_B    = 3,
  parameter int PRESET_VAL  = 6,
  localparam int LENW       = $clog2(DW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdata,
  input  logic              mod_in,
  output logic              mux_out,
  output logic [NREG*DW-1:0] reg_bank,
  output logic              wr_stb,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              mod_stb,
  output logic [DW-1:0]     mod_data,
  output logic [LENW-1:0]   mod_len
);
  localparam int FRAME = AW + DW;
  localparam int CNTW  = $clog2(FRAME + 1);

  function automatic logic [DW-1:0] preset(input int i);
    return (i == PRESET_A || i == PRESET_B) ? DW'(PRESET_VAL) : '0;
  endfunction

  logic [SYNC:0] sck_q, csn_q, sd_q, mi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      csn_q <= '1;
      sd_q  <= '0;
      mi_q  <= '0;
    end else begin
      sck_q <= {sck_q[SYNC-1:0], sclk};
      csn_q <= {csn_q[SYNC-1:0], cs_n};
      sd_q  <= {sd_q[SYNC-1:0], sdata};
      mi_q  <= {mi_q[SYNC-1:0], mod_in};
    end

  wire sck_rise = sck_q[SYNC-1] & ~sck_q[SYNC];
  wire sck_fall = ~sck_q[SYNC-1] & sck_q[SYNC];
  wire csn_now  = csn_q[SYNC-1];
  wire commit   = csn_now & ~csn_q[SYNC];

  logic [FRAME-1:0] sh_main, sh_alt;
  logic [CNTW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_main <= '0;
      sh_alt  <= '0;
      cnt     <= '0;
    end else if (csn_now) begin
      cnt <= '0;
    end else if (sck_rise) begin
      sh_main <= {sh_main[FRAME-2:0], sd_q[SYNC-1]};
      sh_alt  <= {sh_alt[FRAME-2:0], mi_q[SYNC-1]};
      if (cnt != CNTW'(FRAME)) cnt <= cnt + 1'b1;
    end

  logic [DW-1:0] regs [NREG];

  wire             no_addr  = regs[MODCTL_REG][NOADDR_BIT];
  wire             use_alt  = regs[MODCTL_REG][ALT_BIT];
  wire [FRAME-1:0] smp_src  = use_alt ? sh_alt : sh_main;
  wire [AW-1:0]    fr_addr  = sh_main[FRAME-1 -: AW];
  wire [DW-1:0]    fr_data  = sh_main[DW-1:0];

  wire take_smp = commit && cnt >= CNTW'(MIN_LEN) && (no_addr || cnt <= CNTW'(DW));
  wire take_wr  = commit && !no_addr && cnt == CNTW'(FRAME) && int'(fr_addr) < NREG;

  wire [LENW-1:0] smp_len = (cnt > CNTW'(DW)) ? LENW'(DW) : LENW'(cnt);
  logic [DW-1:0]  smp_val;

  always_comb
    for (int i = 0; i < DW; i++)
      smp_val[i] = smp_src[i] && (i < int'(smp_len));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= preset(i);
      wr_stb   <= 1'b0;
      mod_stb  <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      mod_data <= '0;
      mod_len  <= '0;
    end else begin
      wr_stb  <= take_wr;
      mod_stb <= take_smp;
      if (take_wr) begin
        wr_addr <= fr_addr;
        wr_data <= fr_data;
      end
      if (take_smp) begin
        mod_data <= smp_val;
        mod_len  <= smp_len;
      end
      for (int i = 0; i < NREG; i++)
        if (take_wr && fr_addr == AW'(i)) regs[i] <= fr_data;
        else if (take_smp && i == MODDAT_REG) regs[i] <= smp_val;
    end

  logic lb_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lb_bit <= 1'b0;
    else if (sck_fall) lb_bit <= sh_main[0];

  assign mux_out = (regs[MUX_REG][MUX_LSB +: 3] == LOOP_CODE) && lb_bit;

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    assign reg_bank[g*DW +: DW] = regs[g];
  end
endmodule

// File: rtl/serial_reg_slave_chk.sv
module serial_reg_slave_chk #(
  parameter int DW         = 12,
  parameter int AW         = 4,
  parameter int NREG       = 10,
  parameter int MUX_REG    = 7,
  parameter int MODDAT_REG = 9,
  parameter int MUX_LSB    = 6,
  parameter int MIN_LEN    = 2,
  parameter logic [2:0] LOOP_CODE = 3'b101,
  localparam int LENW      = $clog2(DW + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mux_out,
  input logic [NREG*DW-1:0] reg_bank,
  input logic               wr_stb,
  input logic [AW-1:0]      wr_addr,
  input logic [DW-1:0]      wr_data,
  input logic               mod_stb,
  input logic [DW-1:0]      mod_data,
  input logic [LENW-1:0]    mod_len
);
  p_addr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> int'(wr_addr) < NREG);

  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> reg_bank[int'(wr_addr)*DW +: DW] == wr_data);

  p_sample_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mod_stb |-> (int'(mod_len) >= MIN_LEN && int'(mod_len) <= DW));

  p_sample_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mod_stb |-> reg_bank[MODDAT_REG*DW +: DW] == mod_data);

  p_sample_zero_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mod_stb |-> (mod_data >> mod_len) == '0);

  p_bank_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_bank) |-> (wr_stb || mod_stb));

  p_loop_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_bank[MUX_REG*DW+MUX_LSB +: 3] != LOOP_CODE) |-> !mux_out);

  p_one_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && mod_stb));

  p_wr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_mod_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mod_stb |=> !mod_stb);
endmodule

bind serial_reg_slave serial_reg_slave_chk #(
  .DW(DW), .AW(AW), .NREG(NREG), .MUX_REG(MUX_REG), .MODDAT_REG(MODDAT_REG),
  .MUX_LSB(MUX_LSB), .MIN_LEN(MIN_LEN), .LOOP_CODE(LOOP_CODE)
) i_chk (
  .clk(clk), .rst_n(rst_n), .mux_out(mux_out), .reg_bank(reg_bank),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
  .mod_stb(mod_stb), .mod_data(mod_data), .mod_len(mod_len)
);

// File: tb/test_serial_reg_slave.sv
`timescale 1ns/1ps
module test_serial_reg_slave;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdata = 1'b0, mod_in = 1'b0;
  logic mux_out, wr_stb, mod_stb;
  logic [119:0] reg_bank;
  logic [3:0] wr_addr, mod_len;
  logic [11:0] wr_data, mod_data;

  int checks = 0, errors = 0;
  int wr_n = 0, md_n = 0;
  logic [3:0] lw_a, lm_l;
  logic [11:0] lw_d, lm_d;
  logic [11:0] m [10];
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_reg_slave i_serial_reg_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdata(sdata),
    .mod_in(mod_in), .mux_out(mux_out), .reg_bank(reg_bank),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .mod_stb(mod_stb), .mod_data(mod_data), .mod_len(mod_len)
  );

  always @(negedge clk) begin
    if (wr_stb)  begin wr_n++; lw_a = wr_addr; lw_d = wr_data; end
    if (mod_stb) begin md_n++; lm_d = mod_data; lm_l = mod_len; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bank_chk(input string req);
    for (int i = 0; i < 10; i++) chk(req, {20'd0, reg_bank[i*12 +: 12]}, {20'd0, m[i]});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) m[i] = (i == 0 || i == 3) ? 12'h006 : 12'h000;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] mb, input logic [31:0] ab, input int n, input bit lb);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = mb[i];
      mod_in = ab[i];
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      if (lb) begin
        repeat (3) @(negedge clk);
        chk("R8 loopback bit", {31'd0, mux_out}, {31'd0, mb[i]});
        repeat (H - 3) @(negedge clk);
      end else repeat (H) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr16(input int a, input logic [11:0] d);
    xfer({16'd0, a[3:0], d}, 32'd0, 16, 1'b0);
  endtask

  initial begin
    int w0, s0;
    logic [11:0] d, p;
    do_reset();

    bank_chk("R5 reset values");
    chk("R5 mux_out after reset", {31'd0, mux_out}, 0);
    chk("R9 no strobe after reset", wr_n + md_n, 0);

    for (int a = 0; a < 16; a++) begin
      d = 12'((a * 12'h1A7) + 12'h035);
      if (a == 8) d = d & 12'hFFC;
      w0 = wr_n;
      wr16(a, d);
      if (a < 10) begin
        m[a] = d;
        chk("R1 write strobe count", wr_n - w0, 1);
        chk("R1 strobe address", {28'd0, lw_a}, a);
        chk("R1 strobe data", {20'd0, lw_d}, {20'd0, d});
        bank_chk("R1 register bank");
      end else begin
        chk("R4 high address no strobe", wr_n - w0, 0);
        bank_chk("R4 high address bank");
      end
    end

    do_reset();
    xfer(32'h000F25A5, 32'd0, 20, 1'b0);
    m[2] = 12'h5A5;
    bank_chk("R2 long frame last 16 bits");
    chk("R2 long frame address", {28'd0, lw_a}, 2);
    xfer(32'h00E9_4C3D, 32'd0, 24, 1'b0);
    m[4] = 12'hC3D;
    bank_chk("R2 24-bit frame");

    for (int n = 2; n <= 12; n++) begin
      p = 12'(12'h9D3 ^ (n * 12'h135)) & 12'((1 << n) - 1);
      s0 = md_n;
      w0 = wr_n;
      xfer({20'd0, p} | (32'hFFFFF000), 32'd0, n, 1'b0);
      m[9] = p;
      chk("R3 sample strobe count", md_n - s0, 1);
      chk("R3 sample length", {28'd0, lm_l}, n);
      chk("R3 sample data", {20'd0, lm_d}, {20'd0, p});
      chk("R9 no write strobe on sample", wr_n - w0, 0);
      bank_chk("R3 sample bank");
    end

    foreach (d[k]) begin end
    for (int j = 0; j < 5; j++) begin
      int n;
      n = (j == 0) ? 0 : (j == 1) ? 1 : 12 + j - 1;
      s0 = md_n;
      w0 = wr_n;
      xfer(32'h0000FFFF, 32'd0, n, 1'b0);
      chk("R4 discarded length strobes", (md_n - s0) + (wr_n - w0), 0);
      bank_chk("R4 discarded length bank");
    end

    w0 = wr_n;
    s0 = md_n;
    sdata = 1'b1;
    for (int k = 0; k < 5; k++) begin
      repeat (H) @(negedge clk); sclk = 1'b1;
      repeat (H) @(negedge clk); sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk("R10 idle clocks no strobe", (wr_n - w0) + (md_n - s0), 0);
    wr16(4, 12'h3C3);
    m[4] = 12'h3C3;
    chk("R10 following frame address", {28'd0, lw_a}, 4);
    bank_chk("R10 following frame bank");

    wr16(8, 12'h001);
    m[8] = 12'h001;
    s0 = md_n;
    xfer(32'h0000000A, 32'h00000015, 5, 1'b0);
    m[9] = 12'h015;
    chk("R7 alternate pin sample", {20'd0, lm_d}, 32'h015);
    chk("R7 alternate pin strobe", md_n - s0, 1);
    xfer(32'h00005ABC, 32'h0000FFFF, 16, 1'b0);
    m[5] = 12'hABC;
    bank_chk("R7 addressed write from main pin");

    chk("R8 loopback off", {31'd0, mux_out}, 0);
    wr16(7, 12'h140);
    m[7] = 12'h140;
    xfer(32'h0000B2D6, 32'd0, 16, 1'b1);
    m[11] = 12'h2D6;
    m[11] = m[11];
    bank_chk("R8 loopback frame writes");

    do_reset();
    wr16(8, 12'h002);
    m[8] = 12'h002;
    w0 = wr_n;
    s0 = md_n;
    xfer(32'h00007123, 32'd0, 16, 1'b0);
    m[9] = 12'h123;
    chk("R6 16-bit frame as sample data", {20'd0, lm_d}, 32'h123);
    chk("R6 16-bit frame length", {28'd0, lm_l}, 12);
    chk("R6 no addressed write", wr_n - w0, 0);
    bank_chk("R6 bank after 16-bit sample");
    xfer(32'h00002ABC, 32'd0, 14, 1'b0);
    m[9] = 12'hABC;
    chk("R6 14-bit frame data", {20'd0, lm_d}, 32'hABC);
    xfer(32'h00000015, 32'd0, 5, 1'b0);
    m[9] = 12'h015;
    chk("R6 short frame length", {28'd0, lm_l}, 5);
    chk("R6 sample count", md_n - s0, 3);
    bank_chk("R6 final bank");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule